// File: doc/BRIEF.md
# Multi-Mode SPI Master Shifter

This block is the serial engine of an SPI master. One 8-bit shift register sits between a one-word transmit holding buffer and a one-word receive holding buffer. The engine generates its own serial clock from the system clock through a power-of-two divider. It drives or samples the data lines in one of four line modes, chosen by three control inputs.

In full-duplex mode a word written into the transmit buffer starts a frame: the word goes out MSB first on the master-out line while the master-in line is shifted into the same register. In receive-only mode the engine clocks frames from the enable alone and only listens on master-in. Two bidirectional modes share the master-out pin as a single data line. With its output enable set the pin transmits on a buffer write and nothing is received. With its output enable cleared the pin is released and sampled, and frames run from the enable alone. The two listening modes repeat frames back to back and stop only at a frame boundary.

Top module: `spi_line_master`

## Requirements
- R1: After reset, txEmpty is 1, rxFull is 0, busy is 0, sclk is 0 and mosiOut is 0.
- R2: Mode select: bidiMode=0, rxOnly=0 gives full-duplex. In that mode, and in bidirectional transmit (bidiMode=1, bidiOutEn=1), a frame starts on the clock edge after the buffer holds a word written while enable=1. That edge copies the word into the shift register, sets txEmpty and raises busy.
- R3: sclk idles low (mode 0). Data leaves MSB first on mosiOut, changes only on falling sclk edges, and is sampled on rising edges.
- R4: In full-duplex, the 8 bits read on misoIn are written to rxData at the last falling edge of the frame, and rxFull is set. A one-cycle rxRead pulse clears rxFull.
- R5: Receive-only mode (bidiMode=0, rxOnly=1) starts frames as soon as enable is 1, with no write. It repeats frames back to back and, after enable falls, completes the current frame and stops. mosiOe stays 0 throughout.
- R6: Bidirectional transmit drives mosiOut with mosiOe=1, and its frames never set rxFull.
- R7: Bidirectional receive (bidiMode=1, bidiOutEn=0) keeps mosiOe at 0 and samples mosiIn instead of misoIn. It repeats frames back to back until bidiOutEn is set, then stops at the end of the current frame.
- R8: With divSel=N, sclk stays high for 2^N system cycles per bit and low for 2^N. A lone frame keeps busy high for exactly 16*2^N cycles.
- R9: If the transmit buffer is refilled before the last falling edge of a frame, the next frame follows with no idle cycle, and busy stays high across both frames.
- R10: A txWrite while enable=0 is ignored: txEmpty stays 1 and no frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Engine enable |
| bidiMode | input | 1 | 1 selects single-line bidirectional operation |
| rxOnly | input | 1 | 1 selects receive-only when bidiMode is 0 |
| bidiOutEn | input | 1 | Bidirectional direction: 1 transmit, 0 receive |
| divSel | input | 3 | Clock divider exponent N, sclk = clk / 2^(N+1) |
| txWrite | input | 1 | Write strobe for the transmit buffer |
| txData | input | 8 | Word to write into the transmit buffer |
| txEmpty | output | 1 | Transmit buffer can take a word |
| rxRead | input | 1 | Read strobe that consumes the receive buffer |
| rxData | output | 8 | Receive buffer contents |
| rxFull | output | 1 | Receive buffer holds an unread word |
| busy | output | 1 | A frame is in progress |
| sclk | output | 1 | Serial clock |
| mosiOut | output | 1 | Master-out data, also the shared line value |
| mosiOe | output | 1 | Output enable for the master-out pin |
| mosiIn | input | 1 | Value read back from the master-out pin |
| misoIn | input | 1 | Master-in data |

## Verification
A write lands in the buffer at the next edge, so the frame starts one edge later. The bench therefore checks busy and txEmpty at the first and second falling system-clock edges after the strobe. The received word and rxFull appear together at the 16*2^N-th edge after the start. The scoreboard monitor samples rxFull on every falling system-clock edge and compares rxData at the first sample that shows it set. The bench measures busy and sclk-high widths in whole cycles against 16*2^N per frame and 2^N per half bit. The slave model compares the captured master-out word after its eighth rising sclk edge.

// File: rtl/spi_lm_pkg.sv
package spi_lm_pkg;

  typedef enum logic [1:0] {
    LM_DUPLEX  = 2'd0,
    LM_RXONLY  = 2'd1,
    LM_BIDI_TX = 2'd2,
    LM_BIDI_RX = 2'd3
  } lineMode_e;

  // Strobes and selects from control to datapath
  typedef struct packed {
    logic loadShift;  // copy transmit buffer into shift register
    logic sampleBit;  // rising sclk: capture input line
    logic shiftBit;   // falling sclk: advance shift register
    logic storeRx;    // last falling edge: write receive buffer
    logic useMosiIn;  // receive from the shared master-out pin
    logic drive;      // present shift MSB on master-out
  } dpStrobe_t;

  function automatic lineMode_e decodeMode(logic bidi, logic rxOnly, logic outEn);
    if (bidi) return outEn ? LM_BIDI_TX : LM_BIDI_RX;
    return rxOnly ? LM_RXONLY : LM_DUPLEX;
  endfunction

  function automatic logic sendsData(lineMode_e m);
    return (m == LM_DUPLEX) || (m == LM_BIDI_TX);
  endfunction

  function automatic logic takesData(lineMode_e m);
    return m != LM_BIDI_TX;
  endfunction

endpackage

// File: rtl/spi_lm_ctrl.sv
module spi_lm_ctrl
  import spi_lm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  lineMode_e        liveMode,
  input  logic [DIV_W-1:0] divSel,
  input  logic             txEmpty,
  output dpStrobe_t        strobe,
  output logic             busy,
  output logic             sclk,
  output logic             mosiOe
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic             running;
  lineMode_e        frameMode;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] halfLast;
  logic [BIT_W-1:0] bitCnt;
  logic             sclkQ;
  logic             wantStart, tick, riseTick, fallTick, lastFall, keepGoing;

  // half period minus one: 2^divSel - 1
  always_comb begin
    for (int i = 0; i < CNT_W; i++) halfLast[i] = (i < int'(divSel));
  end

  assign wantStart = enable && (sendsData(liveMode) ? !txEmpty : 1'b1);
  assign tick      = running && (divCnt == halfLast);
  assign riseTick  = tick && !sclkQ;
  assign fallTick  = tick && sclkQ;
  assign lastFall  = fallTick && (bitCnt == LAST_BIT);
  assign keepGoing = enable && (liveMode == frameMode) &&
                     (sendsData(frameMode) ? !txEmpty : 1'b1);

  always_comb begin
    strobe.loadShift = (!running && wantStart && sendsData(liveMode)) ||
                       (lastFall && keepGoing && sendsData(frameMode));
    strobe.sampleBit = riseTick;
    strobe.shiftBit  = fallTick;
    strobe.storeRx   = lastFall && takesData(frameMode);
    strobe.useMosiIn = (frameMode == LM_BIDI_RX);
    strobe.drive     = running && sendsData(frameMode);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      frameMode <= LM_DUPLEX;
      divCnt    <= '0;
      bitCnt    <= '0;
      sclkQ     <= 1'b0;
    end else if (!running) begin
      if (wantStart) begin
        running   <= 1'b1;
        frameMode <= liveMode;
        divCnt    <= '0;
        bitCnt    <= '0;
        sclkQ     <= 1'b0;
      end
    end else begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) sclkQ <= ~sclkQ;
      if (fallTick) begin
        if (lastFall) begin
          bitCnt <= '0;
          if (!keepGoing) running <= 1'b0;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  assign busy   = running;
  assign sclk   = sclkQ;
  assign mosiOe = enable && sendsData(liveMode) && !(running && !sendsData(frameMode));

endmodule

// File: rtl/spi_lm_datapath.sv
module spi_lm_datapath
  import spi_lm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] txData,
  input  logic              rxRead,
  input  logic              mosiIn,
  input  logic              misoIn,
  output logic              txEmpty,
  output logic              rxFull,
  output logic [WORD_W-1:0] rxData,
  output logic              mosiOut
);
  logic [WORD_W-1:0] txBuf, shiftReg, rxBuf;
  logic              txEmptyQ, rxFullQ, sampled, lineIn;
  logic [WORD_W-1:0] shiftNext;

  assign lineIn    = strobe.useMosiIn ? mosiIn : misoIn;
  assign shiftNext = {shiftReg[WORD_W-2:0], sampled};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf    <= '0;
      txEmptyQ <= 1'b1;
    end else begin
      if (strobe.loadShift) txEmptyQ <= 1'b1;
      if (wrEn) begin
        txBuf    <= txData;
        txEmptyQ <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sampled  <= 1'b0;
    end else begin
      if (strobe.sampleBit) sampled <= lineIn;
      if (strobe.loadShift) shiftReg <= txBuf;
      else if (strobe.shiftBit) shiftReg <= shiftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf   <= '0;
      rxFullQ <= 1'b0;
    end else begin
      if (rxRead) rxFullQ <= 1'b0;
      if (strobe.storeRx) begin
        rxBuf   <= shiftNext;
        rxFullQ <= 1'b1;
      end
    end
  end

  assign txEmpty = txEmptyQ;
  assign rxFull  = rxFullQ;
  assign rxData  = rxBuf;
  assign mosiOut = strobe.drive && shiftReg[WORD_W-1];

endmodule

// File: rtl/spi_line_master.sv
module spi_line_master
  import spi_lm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              bidiMode,
  input  logic              rxOnly,
  input  logic              bidiOutEn,
  input  logic [DIV_W-1:0]  divSel,
  input  logic              txWrite,
  input  logic [WORD_W-1:0] txData,
  output logic              txEmpty,
  input  logic              rxRead,
  output logic [WORD_W-1:0] rxData,
  output logic              rxFull,
  output logic              busy,
  output logic              sclk,
  output logic              mosiOut,
  output logic              mosiOe,
  input  logic              mosiIn,
  input  logic              misoIn
);
  dpStrobe_t strobe;
  lineMode_e liveMode;

  assign liveMode = decodeMode(bidiMode, rxOnly, bidiOutEn);

  spi_lm_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .liveMode(liveMode),
    .divSel(divSel), .txEmpty(txEmpty), .strobe(strobe), .busy(busy),
    .sclk(sclk), .mosiOe(mosiOe)
  );

  spi_lm_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrEn(txWrite && enable),
    .txData(txData), .rxRead(rxRead), .mosiIn(mosiIn), .misoIn(misoIn),
    .txEmpty(txEmpty), .rxFull(rxFull), .rxData(rxData), .mosiOut(mosiOut)
  );

endmodule

// File: rtl/spi_lm_checker.sv
module spi_lm_checker #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              bidiMode,
  input logic              rxOnly,
  input logic              bidiOutEn,
  input logic [DIV_W-1:0]  divSel,
  input logic              txWrite,
  input logic [WORD_W-1:0] txData,
  input logic              txEmpty,
  input logic              rxRead,
  input logic [WORD_W-1:0] rxData,
  input logic              rxFull,
  input logic              busy,
  input logic              sclk,
  input logic              mosiOut,
  input logic              mosiOe,
  input logic              mosiIn,
  input logic              misoIn
);
  // R3: the serial clock rests low outside a frame
  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  // R3: master-out holds still across each rising sclk edge
  p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $rose(sclk)) |-> $stable(mosiOut));

  // R4: a fresh received word only appears with a falling sclk edge
  p_rx_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> $fell(sclk));

  // R2: the buffer empties only when a frame takes its word
  p_load_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> busy);

  // R5, R7: listening modes never drive the shared pin
  p_no_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (bidiMode && !bidiOutEn) |-> !mosiOe);
  p_no_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!bidiMode && rxOnly) |-> !mosiOe);

  // R10: a disabled, idle engine stays idle
  p_disabled_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !busy) |=> !busy);

endmodule

bind spi_line_master spi_lm_checker #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/sim_spi_line_master.sv
`timescale 1ns/1ps
module sim_spi_line_master;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0, bidiMode = 1'b0, rxOnly = 1'b0, bidiOutEn = 1'b0;
  logic [2:0] divSel = 3'd0;
  logic       txWrite = 1'b0;
  logic [7:0] txData = 8'h00;
  logic       rxRead = 1'b0;
  logic       txEmpty, rxFull, busy, sclk, mosiOut, mosiOe, mosiIn, misoIn;
  logic [7:0] rxData;

  int checks = 0, errors = 0;
  int rxSeen = 0;
  int lastBusyLen = 0, busyCnt = 0, lastHigh = 0, highCnt = 0;
  logic [7:0] rxExp[$];
  logic [7:0] txExp[$];
  logic [7:0] slaveMiso = 8'h00, slaveMosi = 8'h00;
  logic [2:0] sIdx;
  logic [7:0] capWord;
  int         capCnt;
  logic       capOe;

  always #2 clk = ~clk;

  spi_line_master u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .bidiMode(bidiMode), .rxOnly(rxOnly),
    .bidiOutEn(bidiOutEn), .divSel(divSel), .txWrite(txWrite), .txData(txData),
    .txEmpty(txEmpty), .rxRead(rxRead), .rxData(rxData), .rxFull(rxFull),
    .busy(busy), .sclk(sclk), .mosiOut(mosiOut), .mosiOe(mosiOe),
    .mosiIn(mosiIn), .misoIn(misoIn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // slave model: next bit presented after each falling sclk edge
  always @(negedge sclk or negedge rstN)
    if (!rstN) sIdx <= 3'd0; else sIdx <= sIdx + 3'd1;
  assign misoIn = slaveMiso[~sIdx];
  assign mosiIn = slaveMosi[~sIdx];

  // slave capture of master-out on rising sclk (R3: MSB first)
  always @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      capCnt = 0; capWord = 8'h00; capOe = 1'b0;
    end else begin
      capWord = {capWord[6:0], mosiOut};
      capOe   = capOe | mosiOe;
      capCnt++;
      if (capCnt == 8) begin
        if (capOe) begin
          if (txExp.size() == 0) chk(0, "R3 unexpected tx word", capWord, 0);
          else begin
            logic [7:0] e;
            e = txExp.pop_front();
            chk(capWord == e, "R3 serial word", capWord, e);
          end
        end
        capCnt = 0; capOe = 1'b0;
      end
    end
  end

  // width meters for busy and sclk high
  always @(negedge clk) begin
    if (busy) busyCnt++;
    else if (busyCnt > 0) begin lastBusyLen = busyCnt; busyCnt = 0; end
    if (sclk) highCnt++;
    else if (highCnt > 0) begin lastHigh = highCnt; highCnt = 0; end
  end

  // scoreboard monitor for received words (R4)
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rxFull) begin
        if (rxExp.size() == 0) chk(0, "R4 unexpected rx word", rxData, 0);
        else begin
          logic [7:0] e;
          e = rxExp.pop_front();
          chk(rxData == e, "R4 rx word", rxData, e);
        end
        rxSeen++;
        rxRead = 1'b1;
        @(negedge clk);
        rxRead = 1'b0;
      end
    end
  end

  // driver: pushes expectations, then strobes one write
  task automatic sendWord(input logic [7:0] w, input bit expectRx);
    txExp.push_back(w);
    if (expectRx) rxExp.push_back(slaveMiso);
    @(negedge clk);
    txData  = w;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(txEmpty == 1'b1, "R1 txEmpty", txEmpty, 1);
    chk(rxFull == 1'b0, "R1 rxFull", rxFull, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
    chk(mosiOut == 1'b0, "R1 mosiOut", mosiOut, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R10: write while disabled
    @(negedge clk); txData = 8'hEE; txWrite = 1'b1;
    @(negedge clk); txWrite = 1'b0;
    repeat (30) @(negedge clk);
    chk(txEmpty == 1'b1, "R10 txEmpty after disabled write", txEmpty, 1);
    chk(busy == 1'b0, "R10 no frame", busy, 0);

    // R2 R4 R8: full-duplex, divSel=0
    enable = 1'b1; divSel = 3'd0; slaveMiso = 8'h3C;
    txExp.push_back(8'hA5); rxExp.push_back(8'h3C);
    @(negedge clk); txData = 8'hA5; txWrite = 1'b1;
    @(negedge clk); txWrite = 1'b0;
    chk(!txEmpty && !busy, "R2 word held, not started", {txEmpty, busy}, 0);
    @(negedge clk);
    chk(txEmpty && busy, "R2 start and load", {txEmpty, busy}, 3);
    chk(mosiOe == 1'b1, "R2 duplex drives", mosiOe, 1);
    waitIdle();
    chk(lastBusyLen == 16, "R8 busy width N=0", lastBusyLen, 16);
    chk(rxFull == 1'b0, "R4 rxFull cleared by read", rxFull, 0);

    // R9 R8: back-to-back duplex, divSel=2
    divSel = 3'd2; slaveMiso = 8'hC6;
    sendWord(8'h81, 1'b1);
    do @(negedge clk); while (!(busy && txEmpty));
    sendWord(8'h7E, 1'b1);
    waitIdle();
    chk(lastBusyLen == 128, "R9 busy continuous", lastBusyLen, 128);
    chk(lastHigh == 4, "R8 sclk high width N=2", lastHigh, 4);

    // R5: receive-only, divSel=1
    enable = 1'b0; rxOnly = 1'b1; divSel = 3'd1; slaveMiso = 8'h96;
    repeat (4) @(negedge clk);
    base = rxSeen;
    repeat (3) rxExp.push_back(8'h96);
    enable = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b1, "R5 starts on enable", busy, 1);
    chk(mosiOe == 1'b0, "R5 no drive", mosiOe, 0);
    while (rxSeen < base + 2) @(negedge clk);
    enable = 1'b0;
    waitIdle();
    chk(lastBusyLen == 96, "R5 three frames then stop", lastBusyLen, 96);
    repeat (60) @(negedge clk);
    chk(rxSeen == base + 3, "R5 frame count", rxSeen - base, 3);

    // R7: bidirectional receive, divSel=0
    rxOnly = 1'b0; bidiMode = 1'b1; bidiOutEn = 1'b0; divSel = 3'd0;
    slaveMiso = 8'hFF; slaveMosi = 8'h5A;
    base = rxSeen;
    repeat (2) rxExp.push_back(8'h5A);
    enable = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy && !mosiOe, "R7 runs without driving", {busy, mosiOe}, 2);
    while (rxSeen < base + 1) @(negedge clk);
    bidiOutEn = 1'b1;
    @(negedge clk);
    chk(mosiOe == 1'b0, "R7 no drive until frame end", mosiOe, 0);
    waitIdle();
    chk(lastBusyLen == 32, "R7 stops at frame boundary", lastBusyLen, 32);
    chk(rxSeen == base + 2, "R7 frame count", rxSeen - base, 2);

    // R6: bidirectional transmit
    base = rxSeen;
    chk(mosiOe == 1'b1, "R6 drives pin", mosiOe, 1);
    sendWord(8'hC3, 1'b0);
    waitIdle();
    chk(rxSeen == base && rxFull == 1'b0, "R6 nothing received", rxSeen - base, 0);
    chk(lastBusyLen == 16, "R6 busy width", lastBusyLen, 16);

    repeat (10) @(negedge clk);
    chk(rxExp.size() == 0, "R4 all rx words seen", rxExp.size(), 0);
    chk(txExp.size() == 0, "R3 all tx words seen", txExp.size(), 0);
    finishRun();
  end

endmodule